// File: doc/BRIEF.md
# Gated Sample-Clock Divider with Programmable High Time

This block produces a divided sample clock from its input clock. A divider field selects the ratio: a value of zero stops the output and holds it low, and any non-zero value N gives an output period of N+1 input cycles. A second field sets how many input cycles at the start of each period the output stays high. The duty cycle is therefore (1+hi)/(1+N).

The block reads both fields only at period boundaries. A change made in the middle of a period never shortens or stretches the pulse that is already running. A build parameter can remove the high-time field, and the output then runs at close to one half duty. The enable status follows the divider field directly, so the surrounding logic can see whether the clock has been requested.

Top module: `duty_clk_div`

## Requirements
- R1: A divider value of 0 gates the output: once the period in progress ends, the output stays low for as long as the field stays 0.
- R2: A divider value N of 1 or more gives an output period of exactly N+1 input clock cycles.
- R3: With high-time value hi no larger than N, the output is high for the first hi+1 cycles of each period and low for the rest.
- R4: When hi is greater than or equal to N, the high time is clamped to the whole period, and the output stays high without a gap.
- R5: An all-ones divider value gives the widest period of 2^DIV_W input cycles.
- R6: `enabled` is 1 exactly when `divVal` is non-zero. It follows the input in the same cycle, without a register.
- R7: With HAS_HI=0, the output is high for floor((N+1)/2) cycles of each period, and `hiVal` has no effect.
- R8: New divider and high-time values take effect only at the next period start. The period in progress completes with the old values.
- R9: When the block is idle (gated) and the first clock edge sees a non-zero divider, a new period starts on that edge and the output goes high right after it.
- R10: A synchronous `rst` drives the output low on the next edge. After `rst` is released, the first edge starts a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| divVal | input | DIV_W | Divider field: 0 gates the output, N gives a period of N+1 |
| hiVal | input | DIV_W | High-time field: the output is high for hiVal+1 cycles |
| clkOut | output | 1 | Divided clock, registered |
| enabled | output | 1 | 1 when divVal is non-zero |

## Verification
The bench targets four faults. A high-time clamp that wraps instead of saturating would show gaps when hi is greater than N. An off-by-one in the period counter would show up at the all-ones divider, where the period must be exactly 2^DIV_W. A block that loads new fields mid-period would emit a runt or stretched pulse, and the per-cycle pattern compared across a reprogramming catches it. A gate that cuts the output at once would truncate a high phase, and a restart from gated that waits an extra cycle would misalign the first pulse. Both are compared cycle by cycle.

// File: rtl/duty_clk_div_pkg.sv
package duty_clk_div_pkg;
  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic load;  // start a new period with freshly sampled fields
    logic stop;  // period boundary reached while gated: park low
    logic step;  // advance inside the current period
  } divStrb_t;
endpackage

// File: rtl/duty_clk_div_ctrl.sv
module duty_clk_div_ctrl
  import duty_clk_div_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reqOn,
  input  logic     periodEnd,
  output divStrb_t strb
);
  logic running;
  logic atBoundary;

  always_comb begin
    atBoundary = !running || periodEnd;
    strb.load  = atBoundary && reqOn;
    strb.stop  = atBoundary && !reqOn;
    strb.step  = !atBoundary;
  end

  always_ff @(posedge clk) begin
    if (rst)            running <= 1'b0;
    else if (strb.load) running <= 1'b1;
    else if (strb.stop) running <= 1'b0;
  end
endmodule

// File: rtl/duty_clk_div_dp.sv
module duty_clk_div_dp
  import duty_clk_div_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter bit HAS_HI = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divVal,
  input  logic [DIV_W-1:0] hiVal,
  input  divStrb_t         strb,
  output logic             periodEnd,
  output logic             clkOut
);
  localparam int EXT_W = DIV_W + 1;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] curN;
  logic [DIV_W-1:0] curHi;
  logic [DIV_W-1:0] hiEff;

  generate
    if (HAS_HI) begin : g_hiField
      // Saturate the high time to the full period.
      assign hiEff = (hiVal > divVal) ? divVal : hiVal;
    end else begin : g_halfDuty
      logic [EXT_W-1:0] halfLen;
      logic unusedHi;
      assign halfLen  = ({1'b0, divVal} + EXT_W'(1)) >> 1;
      assign hiEff    = DIV_W'(halfLen - EXT_W'(1));
      assign unusedHi = ^hiVal;
    end
  endgenerate

  assign periodEnd = (cnt == curN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      curN   <= '0;
      curHi  <= '0;
      clkOut <= 1'b0;
    end else if (strb.load) begin
      cnt    <= '0;
      curN   <= divVal;
      curHi  <= hiEff;
      clkOut <= 1'b1;
    end else if (strb.stop) begin
      cnt    <= '0;
      clkOut <= 1'b0;
    end else if (strb.step) begin
      cnt    <= cnt + 1'b1;
      clkOut <= (cnt < curHi);
    end
  end
endmodule

// File: rtl/duty_clk_div.sv
module duty_clk_div
  import duty_clk_div_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter bit HAS_HI = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divVal,
  input  logic [DIV_W-1:0] hiVal,
  output logic             clkOut,
  output logic             enabled
);
  divStrb_t strb;
  logic     periodEnd;

  assign enabled = |divVal;

  duty_clk_div_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .reqOn     (enabled),
    .periodEnd (periodEnd),
    .strb      (strb)
  );

  duty_clk_div_dp #(.DIV_W(DIV_W), .HAS_HI(HAS_HI)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .divVal    (divVal),
    .hiVal     (hiVal),
    .strb      (strb),
    .periodEnd (periodEnd),
    .clkOut    (clkOut)
  );
endmodule

// File: rtl/duty_clk_div_chk.sv
module duty_clk_div_chk (
  input logic clk,
  input logic rst,
  input logic enabled,
  input logic clkOut,
  input logic strbLoad,
  input logic strbStop
);
  logic rstQ = 1'b0;
  always_ff @(posedge clk) rstQ <= rst;

  always @(posedge clk) begin
    if (rstQ) AST_RESET_LOW: assert (!clkOut); // R10
  end

  AST_GATED_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!enabled && !clkOut) |=> !clkOut); // R1

  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(clkOut) |-> $past(enabled)); // R8

  AST_LOAD_GOES_HIGH: assert property (@(posedge clk) disable iff (rst)
    strbLoad |=> clkOut); // R9

  AST_STOP_GOES_LOW: assert property (@(posedge clk) disable iff (rst)
    strbStop |=> !clkOut); // R1
endmodule

bind duty_clk_div duty_clk_div_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .enabled  (enabled),
  .clkOut   (clkOut),
  .strbLoad (strb.load),
  .strbStop (strb.stop)
);

// File: tb/duty_clk_div_tb_top.sv
module duty_clk_div_tb_top;
  localparam int DIV_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0] divVal = '0;
  logic [DIV_W-1:0] hiVal  = '0;
  logic clkOut, enabled, clkHalf, enHalf;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  duty_clk_div #(.DIV_W(DIV_W), .HAS_HI(1'b1)) dut_i (
    .clk(clk), .rst(rst), .divVal(divVal), .hiVal(hiVal),
    .clkOut(clkOut), .enabled(enabled));

  duty_clk_div #(.DIV_W(DIV_W), .HAS_HI(1'b0)) dutHalf_i (
    .clk(clk), .rst(rst), .divVal(divVal), .hiVal(hiVal),
    .clkOut(clkHalf), .enabled(enHalf));

  // {divider, high time}
  localparam logic [7:0] VEC [8] = '{
    {4'd1, 4'd0}, {4'd1, 4'd1}, {4'd3, 4'd1}, {4'd15, 4'd7},
    {4'd15, 4'd15}, {4'd5, 4'd9}, {4'd2, 4'd0}, {4'd15, 4'd0}};

  function automatic logic [31:0] patFor(int n, int hi, int len);
    logic [31:0] p = '0;
    for (int k = 0; k < len; k++) p[k] = ((k % (n + 1)) <= hi);
    return p;
  endfunction

  task automatic expectSeq(input int len, input logic [31:0] pat,
                           input bit half, input string req);
    logic [31:0] got = '0;
    for (int k = 0; k < len; k++) begin
      @(posedge clk);
      @(negedge clk);
      got[k] = half ? clkHalf : clkOut;
    end
    checks++;
    if (got != pat) begin
      errors++;
      $display("FAIL %s: pattern actual=%h expected=%h", req, got, pat);
    end
  endtask

  task automatic checkBit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic restart(input int n, input int hi);
    @(negedge clk);
    rst = 1'b1; divVal = DIV_W'(n); hiVal = DIV_W'(hi);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state
    divVal = 4'd3; hiVal = 4'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkBit(clkOut, 1'b0, "R10 reset low");
    checkBit(clkHalf, 1'b0, "R10 reset low half");

    // R2 R3 R4 R5: vector table
    foreach (VEC[i]) begin
      int n  = int'(VEC[i][7:4]);
      int hi = int'(VEC[i][3:0]);
      int he = (hi > n) ? n : hi;
      restart(n, hi);
      expectSeq(2 * (n + 1), patFor(n, he, 2 * (n + 1)), 1'b0, "R2/R3/R4/R5 vector");
    end

    // R8: mid-period reprogramming
    restart(3, 1);
    expectSeq(2, 32'b11, 1'b0, "R8 before change");
    divVal = 4'd1; hiVal = 4'd0;
    expectSeq(5, 32'b10100, 1'b0, "R8 old period completes");

    // R1 and R6: gate mid-run
    restart(3, 2);
    expectSeq(1, 32'b1, 1'b0, "R9 first cycle high");
    divVal = 4'd0;
    #1;
    checkBit(enabled, 1'b0, "R6 enabled drops at once");
    expectSeq(8, 32'b00000011, 1'b0, "R1 gate at boundary");

    // R9 and R6: restart from gated
    divVal = 4'd2; hiVal = 4'd0;
    #1;
    checkBit(enabled, 1'b1, "R6 enabled rises at once");
    expectSeq(3, 32'b001, 1'b0, "R9 restart from gated");

    // R10: reset mid-run while high
    restart(3, 3);
    expectSeq(2, 32'b11, 1'b0, "R4 full high");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkBit(clkOut, 1'b0, "R10 reset mid-run");
    rst = 1'b0;
    expectSeq(1, 32'b1, 1'b0, "R10 fresh period after release");

    // R7: half-duty build ignores hiVal
    restart(3, 0);
    expectSeq(8, 32'h33, 1'b1, "R7 half duty N=3");
    restart(4, 4);
    expectSeq(10, 32'b0001100011, 1'b1, "R7 half duty N=4");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule